// File: doc/BRIEF.md
# Branch-Link Program Counter Sequencer

This block holds the program counter, the instruction-set flag and the processor mode of a core, together with one link register per processor mode. It applies decoded control-flow strobes and computes the next state. A call branches to a target and records where execution must resume. A return branches through the link register, and bit 0 of that register picks the instruction set at the destination. Software can write the link register of the current mode from a general-register value. It can also read that register through a gated read port.

On exception entry the block switches to the entered mode and branches to a vector in the 32-bit instruction set. It also places a return token in the entered mode's link register. The token records the previous mode and instruction set. An exception-return strobe that finds such a token restores both. The resume address then comes from the target input, which the unstacking logic outside this block supplies. Without a token, the strobe behaves as a plain return. With no strobe asserted, the program counter, instruction-set flag and mode hold their values.

Top module: `bl_pc_unit`

## Requirements
- R1: After reset, pc_o equals the RESET_VEC parameter (default 0x1000), isa_o is 0 (32-bit set), mode_o is 0, and every banked link register reads 0.
- R2: A call with no higher-priority strobe sets pc_o to target_i aligned for the current instruction set on the next cycle. In the same update, the current mode's link register becomes pc_o + 8 (isa_o = 0) or pc_o + 4 (isa_o = 1), with bit 0 set equal to isa_o.
- R3: A return sets isa_o to bit 0 of the current link register and pc_o to that register's value with bit 0 cleared. When the new isa_o is 0, bit 1 is also cleared.
- R4: Move-to-link writes gp_i into the current mode's link register. While move-from-link is high, lr_rdata_o shows the current mode's link register in the same cycle. Otherwise lr_rdata_o is 0.
- R5: When a call and a move-to-link arrive in the same cycle, the link register takes the call's return address and gp_i is discarded.
- R6: Each mode has its own link register. A write made in one mode is not visible to, and does not change, the register of any other mode.
- R7: Exception entry sets mode_o to exc_mode_i, isa_o to 0 and pc_o to target_i with bits [1:0] cleared. It loads the entered mode's link register with a token: all ones in bits [AW-1:MW+1], the previous mode in bits [MW:1], and the previous isa_o in bit 0.
- R8: An exception return that finds a token in the current link register restores mode_o and isa_o from the token. It loads pc_o with target_i aligned for the restored instruction set.
- R9: An exception return that finds no token acts exactly as a return (R3).
- R10: Priority for the next PC is exception entry, then exception return, then return, then call. Exception entry also blocks the link writes of call and move-to-link, and a return blocks a simultaneous call's link write.
- R11: With no call, return, exception entry or exception return, pc_o, isa_o and mode_o hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| call_i | input | 1 | Branch-with-link strobe |
| ret_i | input | 1 | Return-through-link strobe |
| mtl_i | input | 1 | Write gp_i into the current link register |
| mfl_i | input | 1 | Read enable for lr_rdata_o |
| exc_i | input | 1 | Exception entry strobe |
| eret_i | input | 1 | Exception return strobe |
| exc_mode_i | input | MW | Mode entered on exception |
| target_i | input | AW | Call target, exception vector or unstacked resume address |
| gp_i | input | AW | General-register value for move-to-link |
| pc_o | output | AW | Program counter |
| isa_o | output | 1 | Instruction set: 0 for 32-bit, 1 for compact 16-bit |
| mode_o | output | MW | Current processor mode |
| lr_rdata_o | output | AW | Link register read value, gated by mfl_i |

## Verification
The bench compares the link value of a call made in the compact set with one made in the 32-bit set. A design with the wrong offset, or one that drops the bit 0 marker, would return into the wrong instruction set. Returns are run to targets whose bit 1 is set, to catch a design that leaves a misaligned 32-bit PC. Several strobes are raised together: a call with move-to-link, and exception entry with call, return and move-to-link. A wrong priority ordering would leave the software value, or corrupt another mode's bank. A full exception round trip then reads back the interrupted mode's link register, to expose banks that share storage. A token lookalike written by software checks that token decoding depends only on the value.

// File: rtl/bl_pc_pkg.sv
package bl_pc_pkg;

    typedef enum logic {
        ISA_WIDE    = 1'b0,
        ISA_COMPACT = 1'b1
    } isa_e;

    localparam int unsigned LINK_OFS_WIDE    = 8;
    localparam int unsigned LINK_OFS_COMPACT = 4;

endpackage

// File: rtl/bl_link_bank.sv
module bl_link_bank #(
    parameter int unsigned AW     = 32,
    parameter int unsigned NMODES = 4,
    parameter int unsigned MW     = (NMODES > 1) ? $clog2(NMODES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic [MW-1:0] wsel_i,
    input  logic [AW-1:0] wdata_i,
    input  logic [MW-1:0] rsel_i,
    output logic [AW-1:0] rdata_o
);

    logic [AW-1:0] bank_q [NMODES];
    logic [AW-1:0] bank_d [NMODES];

    for (genvar g = 0; g < NMODES; g++) begin : g_bank
        always_comb begin
            bank_d[g] = bank_q[g];
            if (we_i && (wsel_i == MW'(g))) begin
                bank_d[g] = wdata_i;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                bank_q[g] <= '0;
            end else begin
                bank_q[g] <= bank_d[g];
            end
        end
    end

    always_comb begin
        rdata_o = '0;
        for (int i = 0; i < NMODES; i++) begin
            if (rsel_i == MW'(i)) begin
                rdata_o = bank_q[i];
            end
        end
    end

    // R6: an entry not selected for writing keeps its value
    assert_bank_isolation_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (we_i && (wsel_i != rsel_i)) |=> $stable(rdata_o) || (rsel_i != $past(rsel_i)));

endmodule

// File: rtl/bl_next_ctl.sv
module bl_next_ctl
    import bl_pc_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned MW = 2
) (
    input  logic [AW-1:0] pc_i,
    input  logic          isa_i,
    input  logic [MW-1:0] mode_i,
    input  logic [AW-1:0] lr_i,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          mtl_i,
    input  logic          exc_i,
    input  logic          eret_i,
    input  logic [MW-1:0] exc_mode_i,
    input  logic [AW-1:0] target_i,
    input  logic [AW-1:0] gp_i,
    output logic [AW-1:0] pc_o,
    output logic          isa_o,
    output logic [MW-1:0] mode_o,
    output logic          lr_we_o,
    output logic [MW-1:0] lr_sel_o,
    output logic [AW-1:0] lr_wdata_o
);

    localparam int unsigned TAG_W = AW - MW - 1;

    function automatic logic [AW-1:0] align_pc(input logic [AW-1:0] a, input logic isa);
        logic [AW-1:0] r;
        r = a;
        r[0] = 1'b0;
        if (isa == ISA_WIDE) begin
            r[1] = 1'b0;
        end
        return r;
    endfunction

    logic          is_token;
    logic [AW-1:0] link_val;
    logic [AW-1:0] token_val;

    always_comb begin
        is_token  = &lr_i[AW-1:MW+1];
        link_val  = pc_i + ((isa_i == ISA_COMPACT) ? AW'(LINK_OFS_COMPACT) : AW'(LINK_OFS_WIDE));
        link_val[0] = isa_i;
        token_val = {{TAG_W{1'b1}}, mode_i, isa_i};
    end

    always_comb begin
        pc_o       = pc_i;
        isa_o      = isa_i;
        mode_o     = mode_i;
        lr_we_o    = 1'b0;
        lr_sel_o   = mode_i;
        lr_wdata_o = gp_i;
        if (exc_i) begin
            mode_o     = exc_mode_i;
            isa_o      = ISA_WIDE;
            pc_o       = align_pc(target_i, ISA_WIDE);
            lr_we_o    = 1'b1;
            lr_sel_o   = exc_mode_i;
            lr_wdata_o = token_val;
        end else begin
            if (eret_i && is_token) begin
                mode_o = lr_i[MW:1];
                isa_o  = lr_i[0];
                pc_o   = align_pc(target_i, lr_i[0]);
            end else if (eret_i || ret_i) begin
                isa_o  = lr_i[0];
                pc_o   = align_pc(lr_i, lr_i[0]);
            end else if (call_i) begin
                pc_o       = align_pc(target_i, isa_i);
                lr_we_o    = 1'b1;
                lr_wdata_o = link_val;
            end
            if (!call_i && mtl_i) begin
                lr_we_o    = 1'b1;
                lr_wdata_o = gp_i;
            end
        end
    end

endmodule

// File: rtl/bl_pc_unit.sv
module bl_pc_unit
    import bl_pc_pkg::*;
#(
    parameter int unsigned     AW        = 32,
    parameter int unsigned     NMODES    = 4,
    parameter int unsigned     MW        = (NMODES > 1) ? $clog2(NMODES) : 1,
    parameter logic [AW-1:0]   RESET_VEC = 32'h0000_1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_i,
    input  logic          ret_i,
    input  logic          mtl_i,
    input  logic          mfl_i,
    input  logic          exc_i,
    input  logic          eret_i,
    input  logic [MW-1:0] exc_mode_i,
    input  logic [AW-1:0] target_i,
    input  logic [AW-1:0] gp_i,
    output logic [AW-1:0] pc_o,
    output logic          isa_o,
    output logic [MW-1:0] mode_o,
    output logic [AW-1:0] lr_rdata_o
);

    typedef struct packed {
        logic [AW-1:0] pc;
        logic          isa;
        logic [MW-1:0] mode;
    } seq_state_t;

    seq_state_t    st_d, st_q;
    logic [AW-1:0] lr_cur;
    logic          lr_we;
    logic [MW-1:0] lr_sel;
    logic [AW-1:0] lr_wdata;
    logic [AW-1:0] nx_pc;
    logic          nx_isa;
    logic [MW-1:0] nx_mode;

    bl_next_ctl #(.AW(AW), .MW(MW)) u_ctl (
        .pc_i       (st_q.pc),
        .isa_i      (st_q.isa),
        .mode_i     (st_q.mode),
        .lr_i       (lr_cur),
        .call_i     (call_i),
        .ret_i      (ret_i),
        .mtl_i      (mtl_i),
        .exc_i      (exc_i),
        .eret_i     (eret_i),
        .exc_mode_i (exc_mode_i),
        .target_i   (target_i),
        .gp_i       (gp_i),
        .pc_o       (nx_pc),
        .isa_o      (nx_isa),
        .mode_o     (nx_mode),
        .lr_we_o    (lr_we),
        .lr_sel_o   (lr_sel),
        .lr_wdata_o (lr_wdata)
    );

    bl_link_bank #(.AW(AW), .NMODES(NMODES), .MW(MW)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (lr_we),
        .wsel_i  (lr_sel),
        .wdata_i (lr_wdata),
        .rsel_i  (st_q.mode),
        .rdata_o (lr_cur)
    );

    always_comb begin
        st_d.pc   = nx_pc;
        st_d.isa  = nx_isa;
        st_d.mode = nx_mode;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.pc   <= RESET_VEC;
            st_q.isa  <= ISA_WIDE;
            st_q.mode <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pc_o       = st_q.pc;
    assign isa_o      = st_q.isa;
    assign mode_o     = st_q.mode;
    assign lr_rdata_o = mfl_i ? lr_cur : '0;

    // R2: call writes the return address of the current set into the link register
    assert_call_link_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (call_i && !exc_i && !eret_i && !ret_i) |=>
        (lr_cur == ($past(st_q.pc) + ($past(st_q.isa) ? AW'(4) : AW'(8)) | AW'($past(st_q.isa)))));

    // R3: the program counter is always aligned for the active instruction set
    assert_pc_align_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pc[0] == 1'b0) && (st_q.isa || (st_q.pc[1] == 1'b0)));

    // R3: a return takes its instruction set from link bit 0
    assert_ret_isa_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !exc_i && !eret_i) |=> (st_q.isa == $past(lr_cur[0])));

    // R7: exception entry switches mode, forces the 32-bit set, plants a token
    assert_exc_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exc_i |=> (st_q.mode == $past(exc_mode_i)) && !st_q.isa && (&lr_cur[AW-1:MW+1]));

    // R11: without control-flow strobes the sequencer state holds
    assert_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(call_i || ret_i || exc_i || eret_i) |=>
        $stable(st_q.pc) && $stable(st_q.isa) && $stable(st_q.mode));

endmodule

// File: tb/tb_bl_pc_unit.sv
module tb_bl_pc_unit;

    localparam int unsigned AW = 32;
    localparam int unsigned MW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          call_i = 0, ret_i = 0, mtl_i = 0, mfl_i = 0, exc_i = 0, eret_i = 0;
    logic [MW-1:0] exc_mode_i = '0;
    logic [AW-1:0] target_i = '0, gp_i = '0;
    logic [AW-1:0] pc_o, lr_rdata_o;
    logic          isa_o;
    logic [MW-1:0] mode_o;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #5 clk = ~clk;

    bl_pc_unit dut (
        .clk(clk), .rst_n(rst_n), .call_i(call_i), .ret_i(ret_i), .mtl_i(mtl_i),
        .mfl_i(mfl_i), .exc_i(exc_i), .eret_i(eret_i), .exc_mode_i(exc_mode_i),
        .target_i(target_i), .gp_i(gp_i), .pc_o(pc_o), .isa_o(isa_o),
        .mode_o(mode_o), .lr_rdata_o(lr_rdata_o)
    );

    task automatic check(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic idle();
        call_i = 0; ret_i = 0; mtl_i = 0; mfl_i = 0; exc_i = 0; eret_i = 0;
    endtask

    // apply strobes already set at a negedge, let one edge pass, release
    task automatic step();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic read_lr(input string tag, input logic [AW-1:0] exp);
        mfl_i = 1;
        #1;
        check(tag, lr_rdata_o, exp);
        mfl_i = 0;
        #1;
    endtask

    task automatic write_lr(input logic [AW-1:0] v);
        @(negedge clk);
        mtl_i = 1; gp_i = v;
        step();
    endtask

    task automatic state(input string tag, input logic [AW-1:0] pc, input logic isa,
                         input logic [MW-1:0] md);
        check({tag, " pc"}, pc_o, pc);
        check({tag, " isa"}, AW'(isa_o), AW'(isa));
        check({tag, " mode"}, AW'(mode_o), AW'(md));
    endtask

    task automatic t_reset();
        state("R1 reset", 32'h1000, 1'b0, 2'd0);
        read_lr("R1 bank0 cleared", 32'h0);
    endtask

    task automatic t_call_ret_wide();
        @(negedge clk); call_i = 1; target_i = 32'h2003; step();
        state("R2 call wide", 32'h2000, 1'b0, 2'd0);
        read_lr("R2 link +8", 32'h1008);
        @(negedge clk); ret_i = 1; step();
        state("R3 ret wide", 32'h1008, 1'b0, 2'd0);
    endtask

    task automatic t_call_ret_compact();
        write_lr(32'h3001);
        read_lr("R4 move to/from link", 32'h3001);
        @(negedge clk); ret_i = 1; step();
        state("R3 ret to compact", 32'h3000, 1'b1, 2'd0);
        @(negedge clk); call_i = 1; target_i = 32'h4001; step();
        state("R2 call compact", 32'h4000, 1'b1, 2'd0);
        read_lr("R2 link +4 marked", 32'h3005);
        @(negedge clk); ret_i = 1; step();
        state("R3 ret compact", 32'h3004, 1'b1, 2'd0);
    endtask

    task automatic t_call_vs_mtl();
        @(negedge clk); call_i = 1; mtl_i = 1; target_i = 32'h5000; gp_i = 32'hDEAD; step();
        check("R5 pc", pc_o, 32'h5000);
        read_lr("R5 call wins link", 32'h3009);
    endtask

    task automatic t_wide_align_hold();
        write_lr(32'h6002);
        @(negedge clk); ret_i = 1; step();
        state("R3 wide alignment", 32'h6000, 1'b0, 2'd0);
        repeat (3) @(posedge clk);
        #1;
        state("R11 hold", 32'h6000, 1'b0, 2'd0);
        check("R4 read gated off", lr_rdata_o, 32'h0);
    endtask

    task automatic t_exception_round_trip();
        write_lr(32'h7001);
        @(negedge clk); ret_i = 1; step();
        state("R3 setup", 32'h7000, 1'b1, 2'd0);
        @(negedge clk); exc_i = 1; exc_mode_i = 2'd2; target_i = 32'h8002; step();
        state("R7 entry", 32'h8000, 1'b0, 2'd2);
        read_lr("R7 token R6 own bank", 32'hFFFF_FFF9);
        @(negedge clk); eret_i = 1; target_i = 32'h7003; step();
        state("R8 token return", 32'h7002, 1'b1, 2'd0);
        read_lr("R6 bank0 preserved", 32'h7001);
        @(negedge clk); eret_i = 1; target_i = 32'h1234; step();
        state("R9 plain eret", 32'h7000, 1'b1, 2'd0);
    endtask

    task automatic t_priority();
        @(negedge clk);
        exc_i = 1; exc_mode_i = 2'd1; target_i = 32'h9000;
        call_i = 1; ret_i = 1; mtl_i = 1; gp_i = 32'h5555;
        step();
        state("R10 exc first", 32'h9000, 1'b0, 2'd1);
        read_lr("R10 bank1 token", 32'hFFFF_FFF9);
        write_lr(32'hB001);
        @(negedge clk); ret_i = 1; call_i = 1; target_i = 32'hC000; step();
        state("R10 ret over call", 32'hB000, 1'b1, 2'd1);
        read_lr("R10 call link blocked", 32'hB001);
        write_lr(32'hFFFF_FFF9);
        @(negedge clk); eret_i = 1; target_i = 32'h7000; step();
        state("R8 soft token", 32'h7000, 1'b1, 2'd0);
        read_lr("R10 bank0 untouched", 32'h7001);
    endtask

    initial begin
        idle();
        #23;
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_call_ret_wide();
        t_call_ret_compact();
        t_call_vs_mtl();
        t_wide_align_hold();
        t_exception_round_trip();
        t_priority();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

endmodule